// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block accepts inbound packets as a 32-bit word stream and stores each one into host memory. It uses buffers that software lists in a ring of two-word receive descriptors. Software programs the ring base and the working descriptor pointer through a small register port. The block then reads descriptors, writes packet words into their buffers and writes a status word back over one word-wide memory master port. Completed packets are signalled by a single-cycle interrupt pulse.

A descriptor occupies 8 bytes. Word 0 carries the control bits and the buffer size, and word 1 carries the buffer address. Bit 31 of word 0 grants the descriptor to hardware. Bit 30 sends the walk back to the ring base. Bit 27 in a written-back status means the packet carries on in the next descriptor. Bits 12:0 give the buffer size in bytes. A packet can span several descriptors. The status of its first descriptor is held back until every other descriptor is closed, so software never sees a partly built chain as owned by the first entry.

Stream rules: the source holds `s_valid`, `s_data`, `s_last` and `s_tail` steady until a cycle where `s_ready` is high. The block drops `s_ready` while it fetches descriptors or writes memory, which gives at most one stream beat per memory write. The memory port keeps `m_valid`, `m_write`, `m_addr` and `m_wdata` steady until `m_ready`. A read returns its data on a later cycle flagged by `m_rvalid`. Only one access is outstanding at a time.

Top module: `rx_ring_writer`

## Requirements
- R1: Register offset 0x04 holds the ring base and offset 0x08 holds the working descriptor pointer. Both read back what was written. Any other offset reads as zero, and a write to it changes neither register.
- R2: While the ring base is zero, an arriving packet is accepted in full (`s_ready` high) and discarded, with no memory access and no interrupt.
- R3: If word 0 at the working pointer has bit 31 clear, the packet is accepted and discarded. There is no memory write and no interrupt, and the pointer stays unchanged.
- R4: Packet words are written one per beat, at rising word addresses starting from the buffer address in word 1. A descriptor takes the smaller of its capacity and the bytes still pending. Its capacity is bits 12:0 rounded down to whole words, so bits 1:0 are ignored.
- R5: On the last beat, `s_tail` gives the valid byte count, with 0 meaning 4. The descriptor that receives the packet's final bytes gets status = its byte count + 4, with all flag bits clear.
- R6: When a descriptor fills before the packet ends, word 0 of the next descriptor is read. If that word is owned, the status is bit 27 OR the byte count and storage moves on to that descriptor. If it is not owned, the status is the byte count alone and the rest of the packet is discarded.
- R7: The status of each descriptor after the first is written as soon as that descriptor closes. The first descriptor's status is the last write of the packet. `irq` pulses high for exactly one cycle, in the cycle after that write is accepted.
- R8: The pointer advances past every descriptor used, including one that closed early. The new value is the ring base when bit 30 of the descriptor's original word 0 is set, and the descriptor address + 8 otherwise.
- R9: A packet longer than 8192 bytes is stored as its first 8192 bytes, and the remaining beats are discarded.
- R10: `s_ready` is never high in a cycle with a memory request pending. A memory request that is not accepted holds its address and direction in the next cycle.
- R11: A descriptor with zero capacity receives no data, and its status is the next-descriptor result of R6 with a byte count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted when high with `s_valid` |
| s_data | input | 32 | Stream word |
| s_last | input | 1 | Final beat of the packet |
| s_tail | input | 2 | Valid bytes in the final beat, 0 = four |
| m_valid | output | 1 | Memory request |
| m_ready | input | 1 | Memory request accepted |
| m_write | output | 1 | Request is a write |
| m_addr | output | ADDR_W | Byte address of the word |
| m_wdata | output | 32 | Write data |
| m_rvalid | input | 1 | Read data returned |
| m_rdata | input | 32 | Read data |
| irq | output | 1 | One-cycle pulse per stored packet |

## Verification
A corrupted working pointer shows up within a packet's first memory request. The descriptor read goes to the wrong address, and the value read back at offset 0x08 after the packet differs from the value computed by wrap and stride. A wrong byte counter or chain decision shows up in the data of the first status write that follows, which lands a few cycles after the descriptor fills. A wrong first-descriptor flag shows up as a status write that comes too early or goes to the wrong address, and as an interrupt that arrives before the last expected write. The bench predicts every memory write of each packet in order from a behavioural model of the ring. It compares each write when it is accepted, so a fault is reported in the cycle it first reaches the port.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
  // descriptor word 0 layout (decoded by software, so positions are fixed)
  localparam int DESC_OWN   = 31;
  localparam int DESC_WRAP  = 30;
  localparam int DESC_CONT  = 27;
  localparam int DESC_LEN_W = 13;
  localparam int DESC_STRIDE    = 8;
  localparam int LAST_STAT_BIAS = 4;
  localparam logic [31:0] CONT_MASK = 32'h1 << DESC_CONT;

  typedef enum logic [3:0] {
    S_IDLE, S_RQ_W0, S_WT_W0, S_RQ_W1, S_WT_W1, S_FILL, S_WR_DATA,
    S_RQ_PEEK, S_WT_PEEK, S_WR_STAT, S_WR_FIRST, S_DRAIN
  } rxr_state_e;
endpackage

// File: rtl/rxr_regs.sv
`timescale 1ns/1ps
module rxr_regs #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              adv,
  input  logic [ADDR_W-1:0] adv_addr,
  output logic [ADDR_W-1:0] ring_start,
  output logic [ADDR_W-1:0] ring_cur
);
  localparam logic [REG_AW-1:0] OFS_START = REG_AW'(4);
  localparam logic [REG_AW-1:0] OFS_CUR   = REG_AW'(8);

  logic wr_start, wr_cur;
  assign wr_start = reg_we && (reg_addr == OFS_START);
  assign wr_cur   = reg_we && (reg_addr == OFS_CUR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_start <= '0;
      ring_cur   <= '0;
    end else begin
      if (wr_start) ring_start <= reg_wdata[ADDR_W-1:0];
      if (adv)         ring_cur <= adv_addr;
      else if (wr_cur) ring_cur <= reg_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_START: reg_rdata = 32'(ring_start);
      OFS_CUR:   reg_rdata = 32'(ring_cur);
      default:   reg_rdata = 32'd0;
    endcase
  end

  // pointer moves only by a full stride or back to the ring base
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_cur) && ring_cur != $past(ring_cur)) |->
      (ring_cur == $past(ring_start) ||
       ring_cur == $past(ring_cur) + ADDR_W'(rxr_pkg::DESC_STRIDE))); // R8
endmodule

// File: rtl/rxr_ctrl.sv
`timescale 1ns/1ps
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_start,
  input  logic [ADDR_W-1:0] ring_cur,
  output logic              adv,
  output logic [ADDR_W-1:0] adv_addr,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [31:0]       s_data,
  input  logic              s_last,
  input  logic [1:0]        s_tail,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [31:0]       m_wdata,
  input  logic              m_rvalid,
  input  logic [31:0]       m_rdata,
  output logic              irq
);
  localparam int TOT_W = $clog2(MAX_BYTES + 1);
  localparam int WRD_W = DESC_LEN_W - 2;

  rxr_state_e state;
  logic [ADDR_W-1:0]     d_addr, first_addr, buf_addr, next_addr;
  logic                  d_wrap, pk_wrap;
  logic [DESC_LEN_W-1:0] d_len, pk_len, d_bytes;
  logic [WRD_W-1:0]      words, cap_words;
  logic [TOT_W-1:0]      tot_bytes;
  logic [TOT_W:0]        tot_next;
  logic [2:0]            beat_bytes;
  logic                  hit_max, first, ended, drain_after, cont_go, irq_q;
  logic [31:0]           wbuf, stat, first_stat, last_stat, mid_stat;

  assign cap_words = d_len[DESC_LEN_W-1:2];
  assign next_addr = d_wrap ? ring_start : d_addr + ADDR_W'(DESC_STRIDE);
  assign beat_bytes = (s_last && s_tail != 2'd0) ? {1'b0, s_tail} : 3'd4;
  assign tot_next  = {1'b0, tot_bytes} + (TOT_W+1)'(beat_bytes);
  assign hit_max   = tot_next >= (TOT_W+1)'(MAX_BYTES);
  assign last_stat = 32'(d_bytes) + 32'(LAST_STAT_BIAS);
  assign mid_stat  = (m_rdata[DESC_OWN] ? CONT_MASK : 32'd0) | 32'(d_bytes);
  assign irq       = irq_q;

  // stream side and pointer advance
  always_comb begin
    s_ready  = (state == S_DRAIN) || (state == S_FILL && words != cap_words);
    adv      = (state == S_WR_DATA && m_ready && ended && first) ||
               (state == S_WT_PEEK && m_rvalid && first) ||
               (state == S_WR_STAT && m_ready);
    adv_addr = next_addr;
  end

  // memory request
  always_comb begin
    m_valid = 1'b0;
    m_write = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    case (state)
      S_RQ_W0:   begin m_valid = 1'b1; m_addr = d_addr; end
      S_RQ_W1:   begin m_valid = 1'b1; m_addr = d_addr + ADDR_W'(4); end
      S_RQ_PEEK: begin m_valid = 1'b1; m_addr = next_addr; end
      S_WR_DATA: begin
        m_valid = 1'b1; m_write = 1'b1;
        m_addr  = buf_addr + ADDR_W'({words, 2'b00});
        m_wdata = wbuf;
      end
      S_WR_STAT:  begin m_valid = 1'b1; m_write = 1'b1; m_addr = d_addr; m_wdata = stat; end
      S_WR_FIRST: begin m_valid = 1'b1; m_write = 1'b1; m_addr = first_addr; m_wdata = first_stat; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      d_addr <= '0; first_addr <= '0; buf_addr <= '0;
      d_wrap <= 1'b0; pk_wrap <= 1'b0; d_len <= '0; pk_len <= '0;
      d_bytes <= '0; words <= '0; tot_bytes <= '0;
      first <= 1'b1; ended <= 1'b0; drain_after <= 1'b0; cont_go <= 1'b0;
      wbuf <= '0; stat <= '0; first_stat <= '0; irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (state)
        S_IDLE: begin
          first <= 1'b1; ended <= 1'b0; drain_after <= 1'b0; tot_bytes <= '0;
          if (s_valid) begin
            if (ring_start == '0) state <= S_DRAIN;
            else begin
              d_addr <= ring_cur; first_addr <= ring_cur; state <= S_RQ_W0;
            end
          end
        end
        S_RQ_W0: if (m_ready) state <= S_WT_W0;
        S_WT_W0: if (m_rvalid) begin
          if (!m_rdata[DESC_OWN]) state <= S_DRAIN;
          else begin
            d_wrap <= m_rdata[DESC_WRAP];
            d_len  <= m_rdata[DESC_LEN_W-1:0];
            state  <= S_RQ_W1;
          end
        end
        S_RQ_W1: if (m_ready) state <= S_WT_W1;
        S_WT_W1: if (m_rvalid) begin
          buf_addr <= m_rdata[ADDR_W-1:0];
          words <= '0; d_bytes <= '0;
          state <= S_FILL;
        end
        S_FILL: begin
          if (words == cap_words) state <= S_RQ_PEEK;
          else if (s_valid) begin
            wbuf        <= s_data;
            d_bytes     <= d_bytes + DESC_LEN_W'(beat_bytes);
            tot_bytes   <= tot_next[TOT_W-1:0];
            ended       <= s_last || hit_max;
            drain_after <= !s_last && hit_max;
            state       <= S_WR_DATA;
          end
        end
        S_WR_DATA: if (m_ready) begin
          words <= words + 1'b1;
          if (ended) begin
            if (first) begin first_stat <= last_stat; state <= S_WR_FIRST; end
            else begin stat <= last_stat; cont_go <= 1'b0; state <= S_WR_STAT; end
          end else state <= S_FILL;
        end
        S_RQ_PEEK: if (m_ready) state <= S_WT_PEEK;
        S_WT_PEEK: if (m_rvalid) begin
          if (first) begin
            first_stat <= mid_stat;
            if (m_rdata[DESC_OWN]) begin
              d_addr <= next_addr;
              d_wrap <= m_rdata[DESC_WRAP];
              d_len  <= m_rdata[DESC_LEN_W-1:0];
              first  <= 1'b0;
              state  <= S_RQ_W1;
            end else begin
              drain_after <= 1'b1;
              state <= S_WR_FIRST;
            end
          end else begin
            stat    <= mid_stat;
            cont_go <= m_rdata[DESC_OWN];
            pk_wrap <= m_rdata[DESC_WRAP];
            pk_len  <= m_rdata[DESC_LEN_W-1:0];
            state   <= S_WR_STAT;
          end
        end
        S_WR_STAT: if (m_ready) begin
          if (cont_go) begin
            d_addr <= next_addr; d_wrap <= pk_wrap; d_len <= pk_len;
            state  <= S_RQ_W1;
          end else begin
            if (!ended) drain_after <= 1'b1;
            state <= S_WR_FIRST;
          end
        end
        S_WR_FIRST: if (m_ready) begin
          irq_q <= 1'b1;
          state <= drain_after ? S_DRAIN : S_IDLE;
        end
        S_DRAIN: if (s_valid && s_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_STREAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_valid)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write))); // R10
  AST_DATA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR_DATA) |-> (words < cap_words)); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(m_valid && m_ready && m_write)); // R7
endmodule

// File: rtl/rx_ring_writer.sv
`timescale 1ns/1ps
module rx_ring_writer #(
  parameter int ADDR_W    = 32,
  parameter int REG_AW    = 4,
  parameter int MAX_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [31:0]       s_data,
  input  logic              s_last,
  input  logic [1:0]        s_tail,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [31:0]       m_wdata,
  input  logic              m_rvalid,
  input  logic [31:0]       m_rdata,
  output logic              irq
);
  logic [ADDR_W-1:0] ring_start, ring_cur, adv_addr;
  logic              adv;

  rxr_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adv(adv),
    .adv_addr(adv_addr), .ring_start(ring_start), .ring_cur(ring_cur)
  );

  rxr_ctrl #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ring_start(ring_start), .ring_cur(ring_cur),
    .adv(adv), .adv_addr(adv_addr),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_tail(s_tail),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rvalid(m_rvalid),
    .m_rdata(m_rdata), .irq(irq)
  );
endmodule

// File: tb/rx_ring_writer_test.sv
`timescale 1ns/1ps
module rx_ring_writer_test;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] WRAP = 32'h4000_0000;
  localparam logic [31:0] CONT = 32'h0800_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic s_valid = 1'b0, s_ready, s_last = 1'b0;
  logic [31:0] s_data = '0;
  logic [1:0] s_tail = '0;
  logic m_valid, m_write, irq;
  logic m_ready = 1'b0, m_rvalid = 1'b0;
  logic [31:0] m_addr, m_wdata, m_rdata = '0;

  int checks = 0, fails = 0, irq_seen = 0, exp_irq = 0, overlap = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr [$];
  logic [31:0] exp_data [$];
  string exp_tag [$];
  logic [31:0] exp_start = 0, exp_cur = 0;
  bit rd_pend = 0;
  logic [31:0] rd_data = 0;

  rx_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_last(s_last), .s_tail(s_tail),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rvalid(m_rvalid), .m_rdata(m_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  function automatic logic [31:0] pword(int s, int i);
    return 32'(s * 65536 + i);
  endfunction

  // memory responder and per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    m_rvalid = rd_pend;
    m_rdata  = rd_data;
    rd_pend  = 0;
    m_ready  = (cyc % 3) != 1;
    if (irq) begin
      irq_seen++;
      check("R7 interrupt only after the last expected write", 32'(exp_addr.size()), 32'd0);
    end
    if (s_ready && m_valid) overlap++;
    if (rst_n && m_valid && m_ready) begin
      if (m_write) begin
        if (exp_addr.size() == 0) check("R3 unexpected memory write", m_addr, 32'hFFFF_FFFF);
        else begin
          check({exp_tag[0], " write address"}, m_addr, exp_addr[0]);
          check({exp_tag[0], " write data"}, m_wdata, exp_data[0]);
          void'(exp_addr.pop_front()); void'(exp_data.pop_front()); void'(exp_tag.pop_front());
        end
        mem[m_addr] = m_wdata;
      end else begin
        rd_pend = 1;
        rd_data = rd(m_addr);
      end
    end
  end

  task automatic push(logic [31:0] a, logic [31:0] d, string t);
    exp_addr.push_back(a); exp_data.push_back(d); exp_tag.push_back(t);
  endtask

  // behavioural ring model: predicts every write of one packet
  task automatic model_pkt(int nbytes, int seed);
    int rem, widx, capb, take, k;
    logic [31:0] d, w0, nw0, bufa, nxt, st, fst, faddr;
    bit first;
    if (exp_start == 0) return;
    d = exp_cur; w0 = rd(d);
    if (!w0[31]) return;
    rem = (nbytes > 8192) ? 8192 : nbytes;
    widx = 0; first = 1; faddr = d; fst = 0;
    forever begin
      bufa = rd(d + 4);
      capb = int'(w0[12:2]) * 4;
      take = (rem < capb) ? rem : capb;
      k = (take + 3) / 4;
      for (int i = 0; i < k; i++) push(bufa + 32'(4 * i), pword(seed, widx + i), "R4");
      widx += k; rem -= take;
      nxt = w0[30] ? exp_start : d + 8;
      if (rem == 0) begin
        st = 32'(take) + 4;
        if (first) fst = st; else push(d, st, "R5");
        exp_cur = nxt;
        break;
      end
      nw0 = rd(nxt);
      st = nw0[31] ? (CONT | 32'(take)) : 32'(take);
      if (first) fst = st; else push(d, st, "R6");
      exp_cur = nxt;
      if (!nw0[31]) break;
      d = nxt; w0 = nw0; first = 0;
    end
    push(faddr, fst, "R7");
    exp_irq++;
  endtask

  task automatic send_pkt(int nbytes, int seed);
    int beats = (nbytes + 3) / 4;
    bit took;
    for (int b = 0; b < beats; b++) begin
      s_valid = 1'b1;
      s_data  = pword(seed, b);
      s_last  = (b == beats - 1);
      s_tail  = 2'(nbytes % 4);
      do begin
        #1 took = s_ready;
        @(negedge clk);
      end while (!took);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic reg_write(logic [3:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic set_desc(logic [31:0] a, logic [31:0] w0, logic [31:0] b);
    mem[a] = w0; mem[a + 4] = b;
  endtask

  task automatic run_pkt(int nbytes, int seed, string tag);
    logic [31:0] v;
    int t = 0;
    model_pkt(nbytes, seed);
    send_pkt(nbytes, seed);
    while ((exp_addr.size() != 0 || irq_seen != exp_irq) && t < 400) begin
      @(negedge clk); t++;
    end
    repeat (4) @(negedge clk);
    check({tag, " R7 all expected writes seen"}, 32'(exp_addr.size()), 32'd0);
    check({tag, " R7 interrupt count"}, 32'(irq_seen), 32'(exp_irq));
    reg_read(4'h8, v);
    check({tag, " R8 working pointer"}, v, exp_cur);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    reg_read(4'h4, v); check("R1 base after reset", v, 32'd0);
    reg_read(4'h8, v); check("R1 pointer after reset", v, 32'd0);
    check("R7 no interrupt after reset", 32'(irq), 32'd0);
    // unknown offset
    reg_write(4'hC, 32'hDEAD_BEEF);
    reg_read(4'hC, v); check("R1 unknown offset reads zero", v, 32'd0);
    reg_read(4'h4, v); check("R1 unknown write leaves base", v, 32'd0);
    reg_read(4'h8, v); check("R1 unknown write leaves pointer", v, 32'd0);
    // R2: disabled ring
    run_pkt(12, 1, "R2 disabled");
    check("R2 no interrupt while disabled", 32'(irq_seen), 32'd0);
    // ring of four
    set_desc(32'h100, OWN | 32'd64, 32'h1000);
    set_desc(32'h108, OWN | 32'd16, 32'h2000);
    set_desc(32'h110, OWN | 32'd32, 32'h3000);
    set_desc(32'h118, OWN | WRAP | 32'd64, 32'h4000);
    reg_write(4'h4, 32'h100); exp_start = 32'h100;
    reg_write(4'h8, 32'h100); exp_cur = 32'h100;
    reg_read(4'h4, v); check("R1 base readback", v, 32'h100);
    run_pkt(10, 2, "R5 single descriptor");
    check("R5 status of lone descriptor", rd(32'h100), 32'd14);
    run_pkt(40, 3, "R6 chain");
    check("R6 first status continues", rd(32'h108), CONT | 32'd16);
    check("R5 last status of chain", rd(32'h110), 32'd28);
    run_pkt(20, 4, "R8 wrap");
    check("R8 wrap returns to base", exp_cur, 32'h100);
    run_pkt(8, 5, "R3 not owned");
    check("R3 pointer unchanged", exp_cur, 32'h100);
    // early end: next not owned
    set_desc(32'h100, OWN | 32'd8, 32'h1000);
    set_desc(32'h108, 32'd16, 32'h2000);
    reg_write(4'h8, 32'h100); exp_cur = 32'h100;
    run_pkt(20, 6, "R6 early end");
    check("R6 early status without continue", rd(32'h100), 32'd8);
    check("R8 pointer past early-ended descriptor", exp_cur, 32'h108);
    // zero capacity descriptor
    set_desc(32'h108, OWN | 32'd0, 32'h2000);
    set_desc(32'h110, OWN | 32'd16, 32'h3000);
    reg_write(4'h8, 32'h108); exp_cur = 32'h108;
    run_pkt(12, 7, "R11 zero capacity");
    check("R11 empty descriptor status", rd(32'h108), CONT);
    check("R5 status after empty descriptor", rd(32'h110), 32'd16);
    // truncation
    set_desc(32'h118, OWN | WRAP | 32'h1FFC, 32'h4000);
    set_desc(32'h100, OWN | 32'd64, 32'h1000);
    reg_write(4'h8, 32'h118); exp_cur = 32'h118;
    run_pkt(9000, 8, "R9 truncation");
    check("R9 first status of long packet", rd(32'h118), CONT | 32'd8188);
    check("R9 truncated tail count", rd(32'h100), 32'd8);
    check("R10 ready never with memory request", 32'(overlap), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule